// File: doc/BRIEF.md
# Stride Run-Length Sequence Expander

This block turns a compact run descriptor into a stream of words that form an arithmetic progression. Each descriptor carries a starting word, a stride and a repeat count. The expander emits the starting word first. It then emits one word per cycle, each equal to the previous word plus the stride, until the repeat count is used up. A run with repeat count N therefore yields N+1 words. For example, start 100, stride 3 and count 4 give 100, 103, 106, 109, 112.

Descriptors enter through a valid/ready handshake. Words leave through a valid/ready stream that carries a flag marking the final word of each run. The block sits between a decompressor front end and a configuration writer. It expands address or data runs that were encoded offline.

Top module: `stride_seq_expander`

## Requirements
- R1: After reset, `out_valid` is 0 and `run_ready` is 1.
- R2: When a descriptor is accepted (`run_valid` and `run_ready` high at a clock edge), the next cycle shows `out_valid` = 1 and `out_word` equal to the accepted `run_base`.
- R3: Each word after the first in a run equals the previous word plus the accepted `run_step`.
- R4: A run with count N emits exactly N+1 words. `out_last` is 1 on the final word only.
- R5: A run with count 0 emits only the base word, with `out_last` = 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_word`, `out_last` and `out_valid` hold their values. No word is lost or repeated.
- R7: `run_ready` is 1 when no run is active. During a run it is 1 only while the final word is on the output and `out_ready` is 1. A descriptor offered while `run_ready` is 0 is ignored and does not change the output stream.
- R8: A descriptor accepted in the same cycle that the final word of a run is consumed has its base on the output in the very next cycle, with no idle gap.
- R9: The addition wraps modulo 2^WORD_W.
- R10: The largest count, 2^COUNT_W - 1, emits 2^COUNT_W words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_valid | input | 1 | Descriptor offered |
| run_ready | output | 1 | Descriptor can be taken this cycle |
| run_base | input | WORD_W | First word of the run |
| run_step | input | WORD_W | Stride added per following word |
| run_count | input | COUNT_W | Number of strides after the first word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | WORD_W | Current sequence word |
| out_last | output | 1 | Current word ends its run |

## Verification
The assertions assume the consumer's `out_ready` and the producer's `run_valid` carry known values after reset. They make no assumption about the producer holding a descriptor until it is taken. The bench therefore changes or withdraws offered descriptors freely, including while `run_ready` is low. Inputs are changed only at the falling edge, and `run_ready` is read after `out_ready` has settled. The random counts are kept small so that many run boundaries, stalls and back-to-back hand-offs occur. Directed cases cover wrap-around and the full count range.

// File: rtl/seq_expander_pkg.sv
package seq_expander_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // A stride counter holding this value has one more word left before the run ends.
  function automatic logic one_left(input logic [31:0] remaining);
    return remaining == 32'd1;
  endfunction
endpackage

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl
  import seq_expander_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_valid,
  input  logic out_ready,
  input  logic final_word,
  output logic run_ready,
  output logic load,
  output logic advance,
  output logic out_valid
);
  phase_e phase_q;
  logic   drain;

  assign out_valid = (phase_q == PH_RUN);
  assign drain     = out_valid && out_ready && final_word;
  assign run_ready = (phase_q == PH_IDLE) || drain;
  assign load      = run_valid && run_ready;
  assign advance   = out_valid && out_ready && !final_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else if (load) begin
      phase_q <= PH_RUN;
    end else if (drain) begin
      phase_q <= PH_IDLE;
    end
  end

  // R6: a stalled word keeps the stream valid
  p_stall_keeps_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);
  // R4: consuming the final word with nothing offered ends the run
  p_run_ends_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && final_word && !run_valid |=> !out_valid);
  // R7: an idle expander always offers ready
  p_idle_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> run_ready);
endmodule

// File: rtl/seq_stride_counter.sv
module seq_stride_counter #(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               advance,
  input  logic [COUNT_W-1:0] load_count,
  output logic               final_word
);
  import seq_expander_pkg::*;
  localparam logic [COUNT_W-1:0] ZERO = '0;

  logic [COUNT_W-1:0] remaining_q;
  logic               last_q;

  assign final_word = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining_q <= ZERO;
      last_q      <= 1'b1;
    end else if (load) begin
      remaining_q <= load_count;
      last_q      <= (load_count == ZERO);
    end else if (advance) begin
      remaining_q <= remaining_q - 1'b1;
      last_q      <= one_left(32'(remaining_q));
    end
  end

  // R4: the registered last flag tracks an exhausted counter
  p_last_tracks_count_r4: assert property (@(posedge clk) disable iff (rst)
    final_word == (remaining_q == ZERO));
  // R4: no stride is taken once the counter is exhausted
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    advance |-> remaining_q != ZERO);
endmodule

// File: rtl/seq_word_accum.sv
module seq_word_accum #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic [WORD_W-1:0] load_base,
  input  logic [WORD_W-1:0] load_step,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] step_q;

  assign word = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      step_q <= '0;
    end else if (load) begin
      word_q <= load_base;
      step_q <= load_step;
    end else if (advance) begin
      word_q <= word_q + step_q;
    end
  end

  // R3, R9: a stride step adds the held stride modulo the word width
  p_stride_add_r3: assert property (@(posedge clk) disable iff (rst)
    advance && !load |=> word == WORD_W'($past(word) + $past(step_q)));
endmodule

// File: rtl/stride_seq_expander.sv
module stride_seq_expander #(
  parameter int WORD_W  = 16,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_valid,
  output logic               run_ready,
  input  logic [WORD_W-1:0]  run_base,
  input  logic [WORD_W-1:0]  run_step,
  input  logic [COUNT_W-1:0] run_count,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_word,
  output logic               out_last
);
  logic load, advance, final_word;

  seq_run_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .run_valid  (run_valid),
    .out_ready  (out_ready),
    .final_word (final_word),
    .run_ready  (run_ready),
    .load       (load),
    .advance    (advance),
    .out_valid  (out_valid)
  );

  seq_stride_counter #(.COUNT_W(COUNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .advance    (advance),
    .load_count (run_count),
    .final_word (final_word)
  );

  seq_word_accum #(.WORD_W(WORD_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .advance   (advance),
    .load_base (run_base),
    .load_step (run_step),
    .word      (out_word)
  );

  assign out_last = out_valid && final_word;

  // R2: an accepted descriptor puts its base on the output next cycle
  p_base_first_r2: assert property (@(posedge clk) disable iff (rst)
    run_valid && run_ready |=> out_valid && out_word == $past(run_base));
  // R6: a stalled word and its flag hold
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_word) && $stable(out_last));
  // R1: nothing is emitted in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/stride_seq_expander_tb_top.sv
module stride_seq_expander_tb_top;
  localparam int W = 16;
  localparam int L = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run_valid = 1'b0;
  logic         run_ready;
  logic [W-1:0] run_base = '0;
  logic [W-1:0] run_step = '0;
  logic [L-1:0] run_count = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_word;
  logic         out_last;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  logic [W-1:0] qw[$];
  logic         ql[$];
  string        qt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stride_seq_expander #(.WORD_W(W), .COUNT_W(L)) dut_i (
    .clk(clk), .rst(rst), .run_valid(run_valid), .run_ready(run_ready),
    .run_base(run_base), .run_step(run_step), .run_count(run_count),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_last(out_last)
  );

  function automatic logic [W-1:0] seq_word(input logic [W-1:0] b, input logic [W-1:0] s, input int k);
    return W'(b + W'(s * k));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  bit stalled_prev = 0;

  // One cycle: called at a falling edge. Checks outputs, drives inputs, updates the model.
  task automatic step(input logic rv, input logic [W-1:0] b, input logic [W-1:0] s,
                      input logic [L-1:0] c, input logic ordy, input string tag_first);
    string t;
    logic  exp_rdy;
    bit    out_fire;
    bit    in_fire;
    bit    busy;
    check("R4 valid", 32'(out_valid), 32'(qw.size() > 0));
    if (qw.size() > 0) begin
      t = stalled_prev ? "R6" : qt[0];
      check({t, " word"}, 32'(out_word), 32'(qw[0]));
      check({t, " last"}, 32'(out_last), 32'(ql[0]));
    end
    run_valid = rv; run_base = b; run_step = s; run_count = c; out_ready = ordy;
    #1;
    exp_rdy = (qw.size() == 0) || (qw.size() == 1 && ordy);
    check("R7 ready", 32'(run_ready), 32'(exp_rdy));
    out_fire = (qw.size() > 0) && ordy;
    in_fire = rv && exp_rdy;
    stalled_prev = (qw.size() > 0) && !ordy;
    busy = qw.size() > 0;
    if (out_fire) begin
      void'(qw.pop_front()); void'(ql.pop_front()); void'(qt.pop_front());
    end
    if (in_fire) begin
      for (int k = 0; k <= int'(c); k++) begin
        qw.push_back(seq_word(b, s, k));
        ql.push_back(k == int'(c));
        if (k == 0) qt.push_back(busy ? "R8" : tag_first);
        else qt.push_back(tag_first == "R2" ? "R3" : tag_first);
      end
    end
    @(negedge clk);
  endtask

  task automatic drain_all();
    for (int i = 0; i < 400 && qw.size() > 0; i++) step(0, '0, '0, '0, 1, "R3");
    step(0, '0, '0, '0, 1, "R3");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        report();
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 run_ready", 32'(run_ready), 32'd1);

    // R2, R3, R4: 100,103,106,109,112
    step(1, 16'd100, 16'd3, 8'd4, 1, "R2");
    drain_all();
    // R5: count zero emits only the base
    step(1, 16'h1234, 16'd7, 8'd0, 1, "R5");
    drain_all();
    // R9: wrap modulo 2^W
    step(1, 16'hFFFE, 16'd5, 8'd3, 1, "R9");
    drain_all();
    // R6 stalls, and R7: a descriptor offered while busy is ignored
    step(1, 16'd500, 16'd10, 8'd3, 1, "R2");
    step(1, 16'd9999, 16'd1, 8'd2, 0, "R7");
    step(1, 16'd8888, 16'd1, 8'd2, 0, "R7");
    step(0, '0, '0, '0, 1, "R7");
    step(1, 16'd7777, 16'd1, 8'd2, 1, "R7");
    drain_all();
    // R8: descriptor held valid, taken as the final word leaves
    step(1, 16'd40, 16'd2, 8'd1, 1, "R2");
    step(1, 16'd60, 16'd4, 8'd2, 1, "R8");
    step(1, 16'd60, 16'd4, 8'd2, 1, "R8");
    drain_all();
    // R10: largest count yields 2^L words
    step(1, 16'd3, 16'd9, 8'hFF, 1, "R10");
    drain_all();

    // Random mix of runs, stalls and withdrawn descriptors
    for (int i = 0; i < 4000; i++) begin
      logic [L-1:0] c;
      c = ($urandom_range(0, 9) == 0) ? L'($urandom_range(0, 40)) : L'($urandom_range(0, 4));
      step(logic'($urandom_range(0, 2) != 0), W'($urandom), W'($urandom), c,
           logic'($urandom_range(0, 3) != 0), "R3");
    end
    drain_all();
    check("R7 idle ready", 32'(run_ready), 32'd1);

    done = 1;
    report();
    $finish;
  end
endmodule